// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

The block combines two 8-input interrupt controllers into one 16-line interrupt source. One controller is the primary and the other is the secondary. The secondary feeds into primary input 2, which is fixed as the cascade input. Requests arrive as events: a valid strobe with a line number and a raise/lower flag. The block keeps a request register, an in-service register and a mask register for each controller. It picks the winning unmasked request and, when the CPU acknowledges, returns an 8-bit vector one cycle later.

A byte-wide register port programs the controllers. Each controller has a command port and a data port. Each controller also has an edge/level configuration register whose writable bits are fixed by a parameter. The command port takes the first initialization word, end-of-interrupt and other operation commands, and the status-read selector. The data port takes the remaining initialization words and, once initialization is complete, the mask.

Top module: `cpic`

## Requirements
- R1: A raise event on line n < 8 sets primary request bit n. A raise event on line n in 8..15 sets secondary request bit n-8 and also primary request bit 2, the cascade input. Request registers reset to 0x00.
- R2: A lower event clears that line's request bit. An event on a line of 16 or more changes no state and pulses `line_err` high for one cycle, in the cycle after the event.
- R3: `int_req` is high when any candidate is pending. Primary bit 2 is never a candidate in its own right. Primary candidates are primary lines 0, 1 and 3..7 whose request bit is set and mask bit is clear. Secondary lines are candidates only while primary bit 2 is requested and unmasked. The lowest-numbered candidate wins, so any primary candidate beats any secondary line.
- R4: `int_ack` with a pending winner produces `vec_valid` in the next cycle. `vec_out` is the owning controller's second-init-word base plus the line index within that controller (modulo 256). An acknowledge with nothing pending produces no `vec_valid`.
- R5: An acknowledge clears the winner's request bit and sets its in-service bit. A secondary win also sets primary in-service bit 2. It clears primary request bit 2 when no other secondary request remains.
- R6: A command-port byte with bit 4 = 1 starts initialization. In that byte, bit 1 means single mode and bit 0 means a fourth word follows. The data-port writes that follow load the base word, then the cascade word (skipped in single mode), then the fourth word (skipped when bit 0 is clear). The controller is then ready.
- R7: A data-port write in the idle or ready state loads the mask, which reads back on the data port. Mask registers reset to 0xFF. Data-port writes during initialization leave the mask untouched. Masked lines do not drive `int_req`.
- R8: A command-port byte with bits 7:5 = 001 and bits 4:3 = 00, written while ready, clears the lowest-numbered set in-service bit of that controller.
- R9: The following operation bytes (bits 4:3 = 00) leave all state unchanged and do not raise `cmd_err`: bits 7:5 = 011, 110 and 010. Any other bits 7:5 value, or any operation byte written while the controller is not ready, pulses `cmd_err` high in the next cycle.
- R10: A command-port byte with bits 4:3 = 01 selects what the command port reads back. Bit 0 = 1 selects the in-service register; 0 (the reset choice) selects the request register.
- R11: Writes to a configuration register are ANDed with that controller's writable-bit parameter (defaults 0xF8 primary, 0xDE secondary). Reads return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Request event strobe |
| irq_raise | input | 1 | 1 raises the line, 0 lowers it |
| irq_line | input | 5 | Line number of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | 0/1 primary command/data, 2/3 secondary command/data, 4/5 primary/secondary configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| int_req | output | 1 | Interrupt pending |
| int_ack | input | 1 | CPU acknowledge pulse |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |
| line_err | output | 1 | Out-of-range line event |
| cmd_err | output | 1 | Rejected operation command |

## Verification
The bench raises single primary lines, single secondary lines, and mixes of both. Mixed requests separate the fixed scan order from arrival order and show that any primary line beats the cascade. Masking a plain line and then the cascade input shows that mask gating works per line and per controller. Initialization is run once with the cascade word and once in single mode. A mask write made directly after the shortened sequence shows whether words were skipped. Repeated end-of-interrupt commands against a known in-service pattern, with the accepted and rejected operation codes placed between them, separate lowest-bit clearing from whole-register clearing or no action.

// File: rtl/cpic.sv
module cpic #(
  parameter logic [7:0] PRI_CFG_WMASK = 8'hF8,
  parameter logic [7:0] SEC_CFG_WMASK = 8'hDE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_valid,
  input  logic       irq_raise,
  input  logic [4:0] irq_line,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       int_req,
  input  logic       int_ack,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic       line_err,
  output logic       cmd_err
);
  localparam int CASC = 2;
  localparam logic [2:0] S_IDLE = 3'd0, S_W2 = 3'd1, S_W3 = 3'd2, S_W4 = 3'd3, S_RDY = 3'd4;

  logic [1:0][7:0] irr, isr, imr, base, cfg;
  logic [1:0][7:0] irr_n, isr_n, imr_n, base_n, cfg_n;
  logic [1:0][2:0] st, st_n;
  logic [1:0][1:0] mode, mode_n;
  logic [1:0]      rsel, rsel_n;
  logic            cerr_n, eoi_hit;

  logic [7:0] pri_cand, sec_cand;
  logic       casc_on, win_sec;
  logic [2:0] win_idx;

  assign pri_cand = irr[0] & ~imr[0] & ~(8'h01 << CASC);
  assign casc_on  = irr[0][CASC] & ~imr[0][CASC];
  assign sec_cand = casc_on ? (irr[1] & ~imr[1]) : 8'h00;
  assign int_req  = (|pri_cand) | (|sec_cand);

  always_comb begin
    win_sec = 1'b0;
    win_idx = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (sec_cand[i]) begin win_sec = 1'b1; win_idx = 3'(i); end
    for (int i = 7; i >= 0; i--)
      if (pri_cand[i]) begin win_sec = 1'b0; win_idx = 3'(i); end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = rsel[0] ? isr[0] : irr[0];
      3'd1:    reg_rdata = imr[0];
      3'd2:    reg_rdata = rsel[1] ? isr[1] : irr[1];
      3'd3:    reg_rdata = imr[1];
      3'd4:    reg_rdata = cfg[0];
      3'd5:    reg_rdata = cfg[1];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    irr_n = irr; isr_n = isr; imr_n = imr; base_n = base; cfg_n = cfg;
    st_n = st; mode_n = mode; rsel_n = rsel;
    cerr_n = 1'b0;
    eoi_hit = 1'b0;

    if (int_ack && int_req) begin
      if (win_sec) begin
        irr_n[1][win_idx] = 1'b0;
        isr_n[1][win_idx] = 1'b1;
        isr_n[0][CASC]    = 1'b1;
        if ((irr[1] & ~(8'h01 << win_idx)) == 8'h00) irr_n[0][CASC] = 1'b0;
      end else begin
        irr_n[0][win_idx] = 1'b0;
        isr_n[0][win_idx] = 1'b1;
      end
    end

    if (irq_valid && !irq_line[4]) begin
      irr_n[irq_line[3]][irq_line[2:0]] = irq_raise;
      if (irq_raise && irq_line[3]) irr_n[0][CASC] = 1'b1;
    end

    if (reg_wr) begin
      case (reg_addr)
        3'd0, 3'd2: begin
          if (reg_wdata[4]) begin
            mode_n[reg_addr[1]] = reg_wdata[1:0];
            st_n[reg_addr[1]]   = S_W2;
          end else if (reg_wdata[3]) begin
            rsel_n[reg_addr[1]] = reg_wdata[0];
          end else if (st[reg_addr[1]] != S_RDY) begin
            cerr_n = 1'b1;
          end else begin
            case (reg_wdata[7:5])
              3'b001: begin
                for (int i = 0; i < 8; i++)
                  if (!eoi_hit && isr_n[reg_addr[1]][i]) begin
                    isr_n[reg_addr[1]][i] = 1'b0;
                    eoi_hit = 1'b1;
                  end
              end
              3'b011, 3'b110, 3'b010: ;
              default: cerr_n = 1'b1;
            endcase
          end
        end
        3'd1, 3'd3: begin
          case (st[reg_addr[1]])
            S_W2: begin
              base_n[reg_addr[1]] = reg_wdata;
              st_n[reg_addr[1]] = mode[reg_addr[1]][1] ? (mode[reg_addr[1]][0] ? S_W4 : S_RDY) : S_W3;
            end
            S_W3:    st_n[reg_addr[1]] = mode[reg_addr[1]][0] ? S_W4 : S_RDY;
            S_W4:    st_n[reg_addr[1]] = S_RDY;
            default: imr_n[reg_addr[1]] = reg_wdata;
          endcase
        end
        3'd4:    cfg_n[0] = reg_wdata & PRI_CFG_WMASK;
        3'd5:    cfg_n[1] = reg_wdata & SEC_CFG_WMASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= {2{8'hFF}}; base <= '0; cfg <= '0;
      st <= {2{S_IDLE}}; mode <= '0; rsel <= '0;
      vec_valid <= 1'b0; vec_out <= 8'h00; line_err <= 1'b0; cmd_err <= 1'b0;
    end else begin
      irr <= irr_n; isr <= isr_n; imr <= imr_n; base <= base_n; cfg <= cfg_n;
      st <= st_n; mode <= mode_n; rsel <= rsel_n;
      vec_valid <= int_ack && int_req;
      if (int_ack && int_req) vec_out <= base[win_sec] + {5'd0, win_idx};
      line_err <= irq_valid && irq_line[4];
      cmd_err  <= cerr_n;
    end
  end
endmodule

// File: rtl/cpic_chk.sv
module cpic_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_raise,
  input logic [4:0]      irq_line,
  input logic            reg_wr,
  input logic [2:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            int_ack,
  input logic            vec_valid,
  input logic            line_err,
  input logic            win_sec,
  input logic [1:0][7:0] irr,
  input logic [1:0][7:0] isr,
  input logic [1:0][2:0] st
);
  a_r2_bad_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> ($past(irq_valid) && $past(irq_line) >= 5'd16));

  a_r1_cascade_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_raise && irq_line[4:3] == 2'b01 && !int_ack) |=> irr[0][2]);

  a_r4_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack));

  a_r5_sec_sets_casc_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(win_sec) && !$past(reg_wr)) |-> isr[0][2]);

  a_r8_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata == 8'h20 && st[0] == 3'd4 && isr[0] != 8'h00 && !int_ack)
      |=> $countones(isr[0]) == $countones($past(isr[0])) - 1);
endmodule

bind cpic cpic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_raise(irq_raise),
  .irq_line(irq_line), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .int_ack(int_ack), .vec_valid(vec_valid), .line_err(line_err),
  .win_sec(win_sec), .irr(irr), .isr(isr), .st(st)
);

// File: tb/cpic_tb_top.sv
module cpic_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_valid = 0, irq_raise = 0, reg_wr = 0, int_ack = 0;
  logic [4:0] irq_line = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata, vec_out;
  logic int_req, vec_valid, line_err, cmd_err;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpic dut_i (.clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_raise(irq_raise),
    .irq_line(irq_line), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid),
    .vec_out(vec_out), .line_err(line_err), .cmd_err(cmd_err));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ev(logic [4:0] line, logic up);
    irq_valid = 1; irq_line = line; irq_raise = up;
    @(negedge clk);
    irq_valid = 0;
  endtask

  task automatic ack(string req, bit expect_vec, logic [7:0] exp);
    if (expect_vec) begin exp_q.push_back(exp); tag_q.push_back(req); end
    int_ack = 1;
    @(negedge clk);
    int_ack = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected vector actual=0x%02h expected=none", vec_out);
      end else chk(tag_q.pop_front(), vec_out, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 missing vectors actual=0 expected=%0d", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 reset request", 3'd0, 8'h00);
    rd("R7 reset mask", 3'd1, 8'hFF);
    chk("R3 reset int_req", {7'd0, int_req}, 8'h00);

    // R6 primary with cascade word and fourth word
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04);
    rd("R6 mask untouched during init", 3'd1, 8'hFF);
    wr(1, 8'h01); wr(1, 8'h00);
    rd("R7 primary mask load", 3'd1, 8'h00);
    // R6 secondary single mode, no fourth word
    wr(2, 8'h12); wr(3, 8'h70); wr(3, 8'h00);
    rd("R6 skip words then mask", 3'd3, 8'h00);

    ev(5, 1);
    rd("R1 primary line 5", 3'd0, 8'h20);
    chk("R3 int_req up", {7'd0, int_req}, 8'h01);
    ev(9, 1);
    rd("R1 secondary line 9", 3'd2, 8'h02);
    rd("R1 cascade bit", 3'd0, 8'h24);
    ev(1, 1);
    ack("R3 lowest primary wins", 1, 8'h21);
    rd("R5 request cleared on ack", 3'd0, 8'h24);
    wr(0, 8'h0B);
    rd("R10 read in-service", 3'd0, 8'h02);
    ack("R3 primary before secondary", 1, 8'h25);
    ack("R4 secondary vector", 1, 8'h71);
    rd("R5 primary in-service with cascade", 3'd0, 8'h26);
    wr(0, 8'h0A);
    rd("R5 cascade request cleared", 3'd0, 8'h00);
    wr(2, 8'h0B);
    rd("R5 secondary in-service", 3'd2, 8'h02);
    wr(2, 8'h0A);
    ack("R4 no pending no vector", 0, 8'h00);

    wr(0, 8'h0B);
    wr(0, 8'h20);
    rd("R8 eoi clears lowest", 3'd0, 8'h24);
    wr(0, 8'h20);
    rd("R8 eoi clears next", 3'd0, 8'h20);
    wr(0, 8'h60);
    chk("R9 specific accepted", {7'd0, cmd_err}, 8'h00);
    wr(0, 8'hC0);
    chk("R9 set-priority accepted", {7'd0, cmd_err}, 8'h00);
    wr(0, 8'h40);
    chk("R9 no-op accepted", {7'd0, cmd_err}, 8'h00);
    rd("R9 accepted ops no change", 3'd0, 8'h20);
    wr(0, 8'hA0);
    chk("R9 invalid op flagged", {7'd0, cmd_err}, 8'h01);
    rd("R9 invalid op no change", 3'd0, 8'h20);
    wr(2, 8'h13);
    wr(2, 8'h20);
    chk("R9 op while initializing", {7'd0, cmd_err}, 8'h01);
    wr(3, 8'h70); wr(3, 8'h01); wr(3, 8'h00);
    rd("R6 single with fourth word", 3'd3, 8'h00);

    wr(0, 8'h0A);
    wr(1, 8'h08);
    ev(3, 1);
    chk("R7 masked line no request", {7'd0, int_req}, 8'h00);
    rd("R7 masked line still latched", 3'd0, 8'h08);
    wr(1, 8'h00);
    chk("R7 unmask raises request", {7'd0, int_req}, 8'h01);
    ack("R4 line 3 vector", 1, 8'h23);

    ev(12, 1);
    wr(1, 8'h04);
    chk("R3 cascade masked gates secondary", {7'd0, int_req}, 8'h00);
    wr(1, 8'h00);
    ack("R4 secondary line 12", 1, 8'h74);

    ev(6, 1);
    ev(6, 0);
    chk("R2 lower clears request", {7'd0, int_req}, 8'h00);
    rd("R2 request register after lower", 3'd0, 8'h00);
    ev(20, 1);
    chk("R2 bad line flagged", {7'd0, line_err}, 8'h01);
    rd("R2 bad line primary untouched", 3'd0, 8'h00);
    rd("R2 bad line secondary untouched", 3'd2, 8'h00);

    wr(4, 8'hFF);
    rd("R11 primary writable bits", 3'd4, 8'hF8);
    wr(5, 8'hFF);
    rd("R11 secondary writable bits", 3'd5, 8'hDE);
    wr(5, 8'h21);
    rd("R11 non-writable bits dropped", 3'd5, 8'h00);

    ev(15, 1);
    ev(0, 1);
    ack("R3 line 0 over line 15", 1, 8'h20);
    ack("R4 line 15 vector", 1, 8'h77);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule